// File: doc/BRIEF.md
# Select/Ready Peripheral Access Sequencer

This block is a local-bus master that carries one host command at a time to one of six external peripheral devices. Each device has an active-low select input that also acts as its strobe, and an active-low ready output that tells when it has taken or produced a word. A command names the device, a word address, the direction, and whether it targets device memory or device registers. The block first asks for the local bus and waits for the grant. It then drives the address, the direction line, the memory/register qualifier and its own ownership acknowledge. One cycle later it drops the select line of the addressed device. It then waits for that device's ready before it closes each 16-bit word.

A memory command moves a 32-bit value as two 16-bit words: the low half at the command address, then the high half at the next address. A register command moves only the low 16 bits. A programmable limit bounds how long the block waits for ready. When the limit runs out, the command is aborted and flagged.

Commands enter on a valid/ready channel. A command is taken on the edge where both are high. `cmd_ready` is high only while the block is idle, so the sender must hold the command and its fields until it is taken. Results leave on a second valid/ready channel. Once `rsp_valid` is high, the result and its error flag stay frozen until `rsp_ready` is seen high. No new command is taken before that.

Top module: `srp_access_seq`

## Requirements
- R1: `cmd_ready` is high exactly when no command is in progress and no response is pending. `rsp_valid` stays high, with `rsp_rdata` and `rsp_err` unchanged, until an edge where `rsp_ready` is high. After reset the block is idle: `cmd_ready`=1, `rsp_valid`=0, `bus_req_n`=1, `bus_ack_n`=1, all `dev_sel_n` high.
- R2: In the cycle after a command with a valid device index is taken, `bus_req_n` goes low. It stays low, with `bus_ack_n` high and no select, until an edge where `bus_gnt_n` is sampled low. `bus_gnt_n` is ignored at any other time.
- R3: In the cycle after the grant edge, the block drives `bus_ack_n`=0, `bus_addr`, `bus_rd` (1 = read, 0 = write) and `bus_mem` (1 = memory, 0 = register), with all selects still high. In the next cycle `dev_sel_n[i]` goes low for device index i. A select is never low while `bus_ack_n` is high.
- R4: A word completes on the first edge where the selected device's `dev_rdy_n` is sampled low. For a read, `bus_rdata` is captured on that edge. Ready inputs of the other devices are ignored. At most one select is low at any time.
- R5: A memory command moves the low half of its data first, at `cmd_addr`. After that word completes, there is one cycle with every select high and `bus_addr` = `cmd_addr`+1 (modulo 2^16), with the high half on `bus_wdata` for a write. The select then goes low again for the second word.
- R6: A register command moves one word. On a write, `bus_wdata` carries `cmd_wdata[15:0]`. On a read, `rsp_rdata[15:0]` holds the word and `rsp_rdata[31:16]` is zero.
- R7: In the cycle after the last word completes, `rsp_valid` is high, and `bus_req_n`, `bus_ack_n` and all selects are high, with `bus_addr`=0, `bus_rd`=1 and `bus_mem`=0.
- R8: Let L = `tmo_limit`, held stable during a command. If L is not zero and ready is not seen on any of the L edges during which a select is low, the command aborts on the L-th such edge: `rsp_err`=1, `rsp_rdata`=0, and the bus is released as in R7. If ready arrives on that same edge, ready wins. L=0 waits without limit. A completed command has `rsp_err`=0.
- R9: A command whose device index is 6 or 7 does not request the bus. In the next cycle it responds with `rsp_err`=1 and `rsp_rdata`=0.
- R10: `bus_wdata_oe` is high only while the bus is owned (`bus_ack_n`=0) by a write command. `bus_wdata` is zero whenever `bus_wdata_oe` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle, command will be taken |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_mem | input | 1 | 1 = device memory (two words), 0 = device register (one word) |
| cmd_dev | input | 3 | Device index, 0 to 5 valid |
| cmd_addr | input | 16 | Word address of the first word |
| cmd_wdata | input | 32 | Write data, low half moved first |
| rsp_valid | output | 1 | Result available |
| rsp_ready | input | 1 | Result taken |
| rsp_rdata | output | 32 | Read result |
| rsp_err | output | 1 | Command aborted (timeout or bad index) |
| tmo_limit | input | 16 | Ready wait limit in strobe cycles, 0 = none |
| bus_req_n | output | 1 | Local bus request, active low |
| bus_gnt_n | input | 1 | Local bus grant, active low |
| bus_ack_n | output | 1 | Bus ownership acknowledge, active low |
| bus_rd | output | 1 | Direction, 1 = read, 0 = write |
| bus_mem | output | 1 | 1 = memory, 0 = register access |
| bus_addr | output | 16 | Word address |
| bus_wdata | output | 16 | Write data word |
| bus_wdata_oe | output | 1 | Write data drive enable |
| bus_rdata | input | 16 | Read data word |
| dev_sel_n | output | 6 | Per-device select/strobe, active low |
| dev_rdy_n | input | 6 | Per-device ready, active low |

## Verification
Directed commands cover every combination of read or write with memory or register access. This separates the one-word and two-word paths, the zeroed upper half and the low-half-only write. Ready latency is placed exactly at, one below, and far beyond the timeout limit, and a zero limit is paired with a long latency. This pins down the edge where ready must beat the abort. The invalid indices 6 and 7 and an address of 0xFFFF check the error shortcut and the address wrap. A random run adds grant delay, response back-pressure, a command held while the block is busy, and spurious ready or grant pulses. This shows that only the addressed device and the arbitration phase can move the sequence.

// File: rtl/srp_pkg.sv
package srp_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARB,
    ST_SETUP,
    ST_STRB,
    ST_GAP,
    ST_DONE
  } seq_st_e;
endpackage

// File: rtl/srp_dev_mux.sv
module srp_dev_mux #(
  parameter int DEV_N = 6,
  parameter int DEV_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DEV_W-1:0] dev_idx,
  input  logic             strobe,
  input  logic [DEV_W-1:0] chk_idx,
  input  logic [DEV_N-1:0] dev_rdy_n,
  output logic [DEV_N-1:0] dev_sel_n,
  output logic             rdy_hit,
  output logic             idx_ok
);
  logic [DEV_N-1:0] hit_vec;

  for (genvar g = 0; g < DEV_N; g++) begin : g_lane
    assign dev_sel_n[g] = !(strobe && (dev_idx == DEV_W'(g)));
    assign hit_vec[g]   = !dev_rdy_n[g] && (dev_idx == DEV_W'(g));
  end

  assign rdy_hit = |hit_vec;
  assign idx_ok  = ({1'b0, chk_idx} < (DEV_W + 1)'(DEV_N));

  assert_one_select_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~dev_sel_n));
endmodule

// File: rtl/srp_timeout.sv
module srp_timeout #(
  parameter int TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [TMO_W-1:0] limit,
  output logic             expire
);
  logic [TMO_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (run) cnt_q <= cnt_q + TMO_W'(1);
    else          cnt_q <= '0;
  end

  assign expire = run && (limit != '0) && (cnt_q == limit - TMO_W'(1));

  assert_wait_bounded_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (run && (limit != '0)) |-> (cnt_q < limit));
endmodule

// File: rtl/srp_ctrl.sv
module srp_ctrl
  import srp_pkg::*;
#(
  parameter int DEV_W  = 3,
  parameter int ADDR_W = 16,
  parameter int HALF_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmd_valid,
  output logic                cmd_ready,
  input  logic                cmd_write,
  input  logic                cmd_mem,
  input  logic [DEV_W-1:0]    cmd_dev,
  input  logic [ADDR_W-1:0]   cmd_addr,
  input  logic [2*HALF_W-1:0] cmd_wdata,
  output logic                rsp_valid,
  input  logic                rsp_ready,
  output logic [2*HALF_W-1:0] rsp_rdata,
  output logic                rsp_err,
  output logic                bus_req_n,
  input  logic                bus_gnt_n,
  output logic                bus_ack_n,
  output logic                bus_rd,
  output logic                bus_mem,
  output logic [ADDR_W-1:0]   bus_addr,
  output logic [HALF_W-1:0]   bus_wdata,
  output logic                bus_wdata_oe,
  input  logic [HALF_W-1:0]   bus_rdata,
  input  logic                rdy_hit,
  input  logic                idx_ok,
  input  logic                expire,
  output logic [DEV_W-1:0]    dev_q,
  output logic                strobe
);
  localparam int FULL_W = 2 * HALF_W;

  seq_st_e             state_q;
  logic                wr_q, mem_q, word_q, err_q;
  logic [ADDR_W-1:0]   addr_q;
  logic [FULL_W-1:0]   wdat_q, rdat_q;
  logic                owned;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      wr_q    <= 1'b0;
      mem_q   <= 1'b0;
      word_q  <= 1'b0;
      err_q   <= 1'b0;
      dev_q   <= '0;
      addr_q  <= '0;
      wdat_q  <= '0;
      rdat_q  <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (cmd_valid) begin
          wr_q   <= cmd_write;
          mem_q  <= cmd_mem;
          dev_q  <= cmd_dev;
          addr_q <= cmd_addr;
          wdat_q <= cmd_wdata;
          word_q <= 1'b0;
          rdat_q <= '0;
          if (idx_ok) begin
            err_q   <= 1'b0;
            state_q <= ST_ARB;
          end else begin
            err_q   <= 1'b1;
            state_q <= ST_DONE;
          end
        end
        ST_ARB:   if (!bus_gnt_n) state_q <= ST_SETUP;
        ST_SETUP: state_q <= ST_STRB;
        ST_STRB: begin
          if (rdy_hit) begin
            if (!wr_q) begin
              if (word_q) rdat_q[FULL_W-1:HALF_W] <= bus_rdata;
              else        rdat_q[HALF_W-1:0]      <= bus_rdata;
            end
            if (mem_q && !word_q) begin
              word_q  <= 1'b1;
              state_q <= ST_GAP;
            end else begin
              state_q <= ST_DONE;
            end
          end else if (expire) begin
            err_q   <= 1'b1;
            rdat_q  <= '0;
            state_q <= ST_DONE;
          end
        end
        ST_GAP:  state_q <= ST_STRB;
        ST_DONE: if (rsp_ready) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign owned        = (state_q == ST_SETUP) || (state_q == ST_STRB) || (state_q == ST_GAP);
  assign strobe       = (state_q == ST_STRB);
  assign cmd_ready    = (state_q == ST_IDLE);
  assign rsp_valid    = (state_q == ST_DONE);
  assign rsp_rdata    = rdat_q;
  assign rsp_err      = err_q;
  assign bus_req_n    = !(owned || (state_q == ST_ARB));
  assign bus_ack_n    = !owned;
  assign bus_rd       = owned ? !wr_q : 1'b1;
  assign bus_mem      = owned && mem_q;
  assign bus_addr     = owned ? addr_q + ADDR_W'(word_q) : '0;
  assign bus_wdata_oe = owned && wr_q;
  assign bus_wdata    = (owned && wr_q) ? (word_q ? wdat_q[FULL_W-1:HALF_W] : wdat_q[HALF_W-1:0])
                                        : '0;

  assert_rsp_held_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata) && $stable(rsp_err)));

  assert_ack_after_grant_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_ack_n) |-> $past(!bus_gnt_n));

  assert_reg_upper_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !mem_q && !wr_q) |-> (rsp_rdata[FULL_W-1:HALF_W] == '0));
endmodule

// File: rtl/srp_access_seq.sv
module srp_access_seq #(
  parameter int DEV_N  = 6,
  parameter int DEV_W  = $clog2(DEV_N + 1),
  parameter int ADDR_W = 16,
  parameter int HALF_W = 16,
  parameter int TMO_W  = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmd_valid,
  output logic                cmd_ready,
  input  logic                cmd_write,
  input  logic                cmd_mem,
  input  logic [DEV_W-1:0]    cmd_dev,
  input  logic [ADDR_W-1:0]   cmd_addr,
  input  logic [2*HALF_W-1:0] cmd_wdata,
  output logic                rsp_valid,
  input  logic                rsp_ready,
  output logic [2*HALF_W-1:0] rsp_rdata,
  output logic                rsp_err,
  input  logic [TMO_W-1:0]    tmo_limit,
  output logic                bus_req_n,
  input  logic                bus_gnt_n,
  output logic                bus_ack_n,
  output logic                bus_rd,
  output logic                bus_mem,
  output logic [ADDR_W-1:0]   bus_addr,
  output logic [HALF_W-1:0]   bus_wdata,
  output logic                bus_wdata_oe,
  input  logic [HALF_W-1:0]   bus_rdata,
  output logic [DEV_N-1:0]    dev_sel_n,
  input  logic [DEV_N-1:0]    dev_rdy_n
);
  logic [DEV_W-1:0] dev_q;
  logic             strobe, rdy_hit, idx_ok, expire;

  srp_dev_mux #(.DEV_N(DEV_N), .DEV_W(DEV_W)) u_mux (
    .clk       (clk),
    .rst_n     (rst_n),
    .dev_idx   (dev_q),
    .strobe    (strobe),
    .chk_idx   (cmd_dev),
    .dev_rdy_n (dev_rdy_n),
    .dev_sel_n (dev_sel_n),
    .rdy_hit   (rdy_hit),
    .idx_ok    (idx_ok)
  );

  srp_timeout #(.TMO_W(TMO_W)) u_tmo (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (strobe),
    .limit  (tmo_limit),
    .expire (expire)
  );

  srp_ctrl #(.DEV_W(DEV_W), .ADDR_W(ADDR_W), .HALF_W(HALF_W)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_valid    (cmd_valid),
    .cmd_ready    (cmd_ready),
    .cmd_write    (cmd_write),
    .cmd_mem      (cmd_mem),
    .cmd_dev      (cmd_dev),
    .cmd_addr     (cmd_addr),
    .cmd_wdata    (cmd_wdata),
    .rsp_valid    (rsp_valid),
    .rsp_ready    (rsp_ready),
    .rsp_rdata    (rsp_rdata),
    .rsp_err      (rsp_err),
    .bus_req_n    (bus_req_n),
    .bus_gnt_n    (bus_gnt_n),
    .bus_ack_n    (bus_ack_n),
    .bus_rd       (bus_rd),
    .bus_mem      (bus_mem),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .bus_wdata_oe (bus_wdata_oe),
    .bus_rdata    (bus_rdata),
    .rdy_hit      (rdy_hit),
    .idx_ok       (idx_ok),
    .expire       (expire),
    .dev_q        (dev_q),
    .strobe       (strobe)
  );

  assert_sel_needs_ack_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_sel_n != '1) |-> !bus_ack_n);

  assert_setup_before_sel_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_ack_n) |-> (dev_sel_n == '1));
endmodule

// File: tb/sim_srp_access_seq.sv
module sim_srp_access_seq;
  localparam int ND = 6;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0, cmd_ready, cmd_write = 1'b0, cmd_mem = 1'b0;
  logic [2:0]  cmd_dev = '0;
  logic [15:0] cmd_addr = '0;
  logic [31:0] cmd_wdata = '0;
  logic        rsp_valid, rsp_ready = 1'b0, rsp_err;
  logic [31:0] rsp_rdata;
  logic [15:0] tmo_limit = '0;
  logic        bus_req_n, bus_gnt_n = 1'b1, bus_ack_n, bus_rd, bus_mem, bus_wdata_oe;
  logic [15:0] bus_addr, bus_wdata, bus_rdata = '0;
  logic [ND-1:0] dev_sel_n, dev_rdy_n = '1;

  srp_access_seq u0 (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_write(cmd_write), .cmd_mem(cmd_mem),
    .cmd_dev(cmd_dev), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
    .tmo_limit(tmo_limit),
    .bus_req_n(bus_req_n), .bus_gnt_n(bus_gnt_n), .bus_ack_n(bus_ack_n), .bus_rd(bus_rd),
    .bus_mem(bus_mem), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_wdata_oe(bus_wdata_oe),
    .bus_rdata(bus_rdata), .dev_sel_n(dev_sel_n), .dev_rdy_n(dev_rdy_n)
  );

  typedef struct {
    bit w; bit m; int dev; int addr; logic [31:0] data; int lim; int lat; int glat;
  } cmd_t;
  cmd_t q[$];

  int vectors = 0, miscompares = 0;

  // reference model state: 0 idle, 1 waiting grant, 2 setup, 3 strobe, 4 gap, 5 respond
  int ph = 0, mdev = 0, maddr = 0, mword = 0, mcnt = 0, mlim = 0, mlat = 0, mglat = 0, garb = 0;
  bit mw = 0, mm = 0, merr = 0;
  logic [31:0] mwd = '0, mrd = '0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s at %0t: actual=%0h expected=%0h", tag, $time, act, exp);
    end
  endtask

  task automatic compare_all();
    bit own;
    logic [5:0] esel;
    own  = (ph >= 2) && (ph <= 4);
    esel = (ph == 3) ? ~(6'b1 << mdev) : 6'h3F;
    vectors++;
    chk("R1 cmd_ready", 32'(cmd_ready), 32'(ph == 0));
    chk("R1 R7 rsp_valid", 32'(rsp_valid), 32'(ph == 5));
    chk("R2 bus_req_n", 32'(bus_req_n), 32'(!(ph >= 1 && ph <= 4)));
    chk("R3 bus_ack_n", 32'(bus_ack_n), 32'(!own));
    chk("R3 bus_rd", 32'(bus_rd), 32'(own ? !mw : 1'b1));
    chk("R3 bus_mem", 32'(bus_mem), 32'(own && mm));
    chk("R5 bus_addr", 32'(bus_addr), own ? ((maddr + mword) & 32'hFFFF) : 32'h0);
    chk("R4 dev_sel_n", 32'(dev_sel_n), 32'(esel));
    chk("R10 bus_wdata_oe", 32'(bus_wdata_oe), 32'(own && mw));
    chk("R6 R10 bus_wdata", 32'(bus_wdata),
        (own && mw) ? (mword != 0 ? 32'(mwd[31:16]) : 32'(mwd[15:0])) : 32'h0);
    if (ph == 5) begin
      chk("R6 R8 rsp_rdata", rsp_rdata, mrd);
      chk("R8 R9 rsp_err", 32'(rsp_err), 32'(merr));
    end
  endtask

  task automatic drive_inputs();
    if (q.size() > 0 && (ph != 0 || $urandom_range(0, 3) != 0)) begin
      cmd_valid = 1'b1;
      cmd_write = q[0].w;
      cmd_mem   = q[0].m;
      cmd_dev   = 3'(q[0].dev);
      cmd_addr  = 16'(q[0].addr);
      cmd_wdata = q[0].data;
      if (ph == 0) tmo_limit = 16'(q[0].lim);
    end else begin
      cmd_valid = 1'b0;
    end
    if (ph == 1) bus_gnt_n = !(garb >= mglat);
    else if (ph >= 2 && ph <= 4) bus_gnt_n = 1'b0;
    else bus_gnt_n = ($urandom_range(0, 3) != 0);
    for (int d = 0; d < ND; d++) begin
      if (ph == 3 && d == mdev) dev_rdy_n[d] = !(mcnt >= mlat);
      else if (ph != 3 && d == mdev) dev_rdy_n[d] = 1'b1;
      else dev_rdy_n[d] = ($urandom_range(0, 4) != 0);
    end
    bus_rdata = 16'($urandom);
    rsp_ready = ($urandom_range(0, 2) != 0);
  endtask

  task automatic model_step();
    case (ph)
      0: if (cmd_valid) begin
        mw = q[0].w; mm = q[0].m; mdev = q[0].dev; maddr = q[0].addr; mwd = q[0].data;
        mlim = q[0].lim; mlat = q[0].lat; mglat = q[0].glat;
        void'(q.pop_front());
        mword = 0; mrd = '0; garb = 0;
        if (mdev >= ND) begin ph = 5; merr = 1; end
        else begin ph = 1; merr = 0; end
      end
      1: if (!bus_gnt_n) ph = 2; else garb++;
      2: begin ph = 3; mcnt = 0; end
      3: begin
        if (!dev_rdy_n[mdev]) begin
          if (!mw) begin
            if (mword != 0) mrd[31:16] = bus_rdata;
            else mrd[15:0] = bus_rdata;
          end
          if (mm && mword == 0) begin mword = 1; ph = 4; end
          else ph = 5;
        end else if (mlim != 0 && mcnt == mlim - 1) begin
          merr = 1; mrd = '0; ph = 5;
        end else mcnt++;
      end
      4: begin ph = 3; mcnt = 0; end
      5: if (rsp_ready) ph = 0;
      default: ph = 0;
    endcase
  endtask

  task automatic add(input bit w, input bit m, input int dev, input int addr,
                     input logic [31:0] data, input int lim, input int lat, input int glat);
    cmd_t c;
    c.w = w; c.m = m; c.dev = dev; c.addr = addr; c.data = data;
    c.lim = lim; c.lat = lat; c.glat = glat;
    q.push_back(c);
  endtask

  initial begin
    int cyc;
    // directed commands
    add(0, 1, 0, 16'h0100, 32'h0, 0, 0, 0);          // R5 memory read, fast device
    add(1, 1, 5, 16'h2000, 32'hA5A5_1234, 0, 3, 2);  // R5 memory write
    add(0, 0, 2, 16'h0033, 32'h0, 0, 2, 1);          // R6 register read, upper zero
    add(1, 0, 3, 16'h0044, 32'hDEAD_BEEF, 0, 1, 0);  // R6 register write, low half only
    add(0, 1, 1, 16'h0050, 32'h0, 4, 100, 0);        // R8 timeout on first word
    add(1, 0, 4, 16'h0060, 32'h1111_2222, 1, 5, 0);  // R8 limit of one
    add(0, 0, 2, 16'h0070, 32'h0, 4, 3, 0);          // R8 ready on last allowed edge
    add(0, 0, 2, 16'h0071, 32'h0, 4, 4, 0);          // R8 ready one edge late
    add(0, 1, 0, 16'h0080, 32'h0, 0, 20, 3);         // R8 zero limit waits
    add(1, 1, 6, 16'h0090, 32'h5555_6666, 0, 0, 0);  // R9 bad index 6
    add(0, 0, 7, 16'h0091, 32'h0, 0, 0, 0);          // R9 bad index 7
    add(0, 1, 3, 16'hFFFF, 32'h0, 0, 1, 0);          // R5 address wrap
    add(1, 1, 4, 16'hFFFF, 32'h0F0F_F0F0, 0, 0, 0);  // R5 write wrap
    for (int i = 0; i < 150; i++) begin
      int l;
      l = ($urandom_range(0, 2) == 0) ? 0 : int'($urandom_range(3, 8));
      add($urandom_range(0, 1), $urandom_range(0, 1),
          ($urandom_range(0, 9) == 0) ? int'($urandom_range(6, 7)) : int'($urandom_range(0, 5)),
          int'($urandom_range(0, 65535)), $urandom, l,
          int'($urandom_range(0, 4)), int'($urandom_range(0, 3)));
    end

    // reset state, R1
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      compare_all();
    end
    rst_n = 1'b1;

    cyc = 0;
    while ((q.size() > 0 || ph != 0) && cyc < 100000) begin
      @(negedge clk);
      compare_all();
      drive_inputs();
      model_step();
      cyc++;
    end
    if (cyc >= 100000) begin
      miscompares++;
      $display("FAIL watchdog: run did not drain, actual=%0d cycles expected<100000", cyc);
    end
    cmd_valid = 1'b0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      compare_all();
      drive_inputs();
      model_step();
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule